// File: doc/BRIEF.md
# SECDED-Protected Register File

This block is a 32-entry general-purpose register file for a three-operand integer pipeline. It has two read ports and one write port, so two source operands can be read in the same cycle as one result is written. Each 32-bit word is stored as a 39-bit codeword: an extended Hamming code with six position-parity bits and one parity bit over the whole word. The code bits are generated on every write. On every read they are decoded: a single flipped bit is corrected before the data leaves the block, and a two-bit error is flagged as uncorrectable.

Entry 0 is the zero register. It always reads as zero on both ports, and writes to it are dropped. The read ports are combinational and there is no internal bypass. A read of an entry that is being written in the same cycle therefore returns the value held before the write.

A test input XORs a 39-bit mask into one stored codeword. This lets a bench plant single-bit and double-bit faults and then watch the correction path at the ports.

Top module: `ecc_regfile`

## Requirements
- R1: After reset, every entry reads as zero on both ports, with all error flags low.
- R2: A word written to a non-zero entry reads back unchanged on either port from the cycle after the write, with both flags low. The two ports read independent addresses in the same cycle.
- R3: A read of an entry in the same cycle as a write to that entry returns the value held before the write.
- R4: A read of address 0 on either port returns zero with both flags low, whatever has been written to address 0.
- R5: After a one-hot injection mask is applied to a non-zero entry, reads of that entry return the original data with the corrected flag high and the uncorrectable flag low. This holds for each of the 39 codeword bit positions.
- R6: After an injection mask with exactly two bits set is applied to a non-zero entry, reads of that entry raise the uncorrectable flag and keep the corrected flag low.
- R7: On each port the corrected flag and the uncorrectable flag are never high together. Injection into address 0 has no effect.
- R8: An injection changes the stored codeword at the clock edge, and the fault stays until the entry is rewritten. Masks applied to the same entry accumulate by XOR. When a write and an injection target the same entry in the same cycle, the write wins and the entry reads back clean.
- R9: Injection mask bit i flips bit i of the 39-bit stored codeword. Bits 0 to 38 are all reachable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low; clears all entries |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 5 | Write destination entry |
| wrData | input | 32 | Write data |
| rdAddrA | input | 5 | Read port A address |
| rdAddrB | input | 5 | Read port B address |
| rdDataA | output | 32 | Corrected data for port A |
| rdDataB | output | 32 | Corrected data for port B |
| corrA | output | 1 | Port A: single-bit error corrected |
| uncorrA | output | 1 | Port A: uncorrectable error detected |
| corrB | output | 1 | Port B: single-bit error corrected |
| uncorrB | output | 1 | Port B: uncorrectable error detected |
| injEn | input | 1 | Test: fault-injection strobe |
| injAddr | input | 5 | Test: entry that receives the mask |
| injMask | input | 39 | Test: bits XORed into the stored codeword |

## Verification
The assertions assume known control inputs while out of reset. They assume that any entry read after injection carries at most two flipped bits in total, since three or more flips fall outside what the code can classify. The readback property holds only because the same-address write-beats-injection rule keeps a freshly written entry clean. The bench keeps within these limits: it rewrites an entry to clear its fault before planting a new one, it uses only one-hot or two-hot masks, and it tracks the accumulated mask of every entry so that the expected flags follow from the mask's population count.

// File: rtl/ecc_regfile_pkg.sv
package ecc_regfile_pkg;
  localparam int NUM_REGS = 32;
  localparam int ADDR_W   = $clog2(NUM_REGS);
  localparam int DATA_W   = 32;
  localparam int HAM_BITS = 6;
  localparam int CODE_W   = DATA_W + HAM_BITS + 1;
  localparam int NUM_RD   = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic                wrStrobe;
    logic [ADDR_W-1:0]   wrIdx;
    logic                injStrobe;
    logic [ADDR_W-1:0]   injIdx;
    logic [CODE_W-1:0]   injMask;
    logic [NUM_RD-1:0]   rdLive;
  } rfCtrl_t;
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import ecc_regfile_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  // bit 0: overall parity; bits 1..CODE_W-1: Hamming positions,
  // powers of two hold check bits, the rest hold data in ascending order
  always_comb begin
    int j;
    logic par;
    code = '0;
    j = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        code[p] = data[j];
        j++;
      end
    end
    for (int k = 0; k < HAM_BITS; k++) begin
      par = 1'b0;
      for (int p = 1; p < CODE_W; p++) begin
        if (((p >> k) & 1) == 1 && (p & (p - 1)) != 0) par = par ^ code[p];
      end
      code[1 << k] = par;
    end
    code[0] = ^code[CODE_W-1:1];
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import ecc_regfile_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data,
  output logic              corrected,
  output logic              uncorrectable
);
  logic [HAM_BITS-1:0] syn;
  logic                allPar;
  logic [CODE_W-1:0]   fixed;
  logic                synInRange;

  always_comb begin
    syn = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (code[p]) syn = syn ^ HAM_BITS'(p);
    end
    allPar     = ^code;
    synInRange = int'(syn) < CODE_W;
  end

  always_comb begin
    fixed = code;
    if (allPar && syn != '0 && synInRange) fixed[syn] = ~code[syn];
  end

  // odd overall parity with a valid position is a single flip (position 0
  // when the syndrome is zero); even parity with a non-zero syndrome is double
  assign corrected     = allPar && synInRange;
  assign uncorrectable = (!allPar && syn != '0) || (allPar && !synInRange);

  always_comb begin
    int j;
    data = '0;
    j = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        data[j] = fixed[p];
        j++;
      end
    end
  end
endmodule

// File: rtl/rf_control.sv
module rf_control
  import ecc_regfile_pkg::*;
(
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic                injEn,
  input  logic [ADDR_W-1:0]   injAddr,
  input  logic [CODE_W-1:0]   injMask,
  input  logic [ADDR_W-1:0]   rdAddr [NUM_RD],
  output rfCtrl_t             ctrl
);
  logic wrLive;
  logic injClash;

  assign wrLive   = wrEn && (wrAddr != '0);
  assign injClash = wrLive && (wrAddr == injAddr);

  always_comb begin
    ctrl.wrStrobe  = wrLive;
    ctrl.wrIdx     = wrAddr;
    ctrl.injStrobe = injEn && (injAddr != '0) && !injClash;
    ctrl.injIdx    = injAddr;
    ctrl.injMask   = injMask;
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : gRdLive
    assign ctrl.rdLive[g] = (rdAddr[g] != '0);
  end
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import ecc_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rfCtrl_t           ctrl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr [NUM_RD],
  output logic [DATA_W-1:0] rdData [NUM_RD],
  output logic              rdCorr [NUM_RD],
  output logic              rdUncorr [NUM_RD]
);
  logic [CODE_W-1:0] mem [NUM_REGS];
  logic [CODE_W-1:0] wrCode;

  secded_enc u_enc (.data(wrData), .code(wrCode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else begin
      if (ctrl.wrStrobe)  mem[ctrl.wrIdx]  <= wrCode;
      if (ctrl.injStrobe) mem[ctrl.injIdx] <= mem[ctrl.injIdx] ^ ctrl.injMask;
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : gRead
    logic [DATA_W-1:0] decData;
    logic              decCorr;
    logic              decUnc;

    secded_dec u_dec (
      .code(mem[rdAddr[g]]), .data(decData),
      .corrected(decCorr), .uncorrectable(decUnc)
    );

    assign rdData[g]   = ctrl.rdLive[g] ? decData : '0;
    assign rdCorr[g]   = ctrl.rdLive[g] && decCorr;
    assign rdUncorr[g] = ctrl.rdLive[g] && decUnc;

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
      !(rdCorr[g] && rdUncorr[g]));
  end

  // checker state: last injection target and the word it should now hold
  logic              prevInj;
  logic [ADDR_W-1:0] prevInjIdx;
  logic [CODE_W-1:0] prevInjWord;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevInj     <= 1'b0;
      prevInjIdx  <= '0;
      prevInjWord <= '0;
    end else begin
      prevInj     <= ctrl.injStrobe;
      prevInjIdx  <= ctrl.injIdx;
      prevInjWord <= mem[ctrl.injIdx] ^ ctrl.injMask;
    end
  end

  assert_inject_applied_R8: assert property (@(posedge clk) disable iff (!rstN)
    prevInj |-> mem[prevInjIdx] == prevInjWord);

  assert_entry0_clean_R4: assert property (@(posedge clk) disable iff (!rstN)
    mem[0] == '0);
endmodule

// File: rtl/ecc_regfile.sv
module ecc_regfile
  import ecc_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [4:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic [4:0]        rdAddrA,
  input  logic [4:0]        rdAddrB,
  output logic [31:0]       rdDataA,
  output logic [31:0]       rdDataB,
  output logic              corrA,
  output logic              uncorrA,
  output logic              corrB,
  output logic              uncorrB,
  input  logic              injEn,
  input  logic [4:0]        injAddr,
  input  logic [38:0]       injMask
);
  rfCtrl_t           ctrl;
  logic [ADDR_W-1:0] rdAddr   [NUM_RD];
  logic [DATA_W-1:0] rdData   [NUM_RD];
  logic              rdCorr   [NUM_RD];
  logic              rdUncorr [NUM_RD];

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;

  rf_control u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .injEn(injEn), .injAddr(injAddr),
    .injMask(injMask), .rdAddr(rdAddr), .ctrl(ctrl)
  );

  rf_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .rdCorr(rdCorr), .rdUncorr(rdUncorr)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];
  assign corrA   = rdCorr[0];
  assign uncorrA = rdUncorr[0];
  assign corrB   = rdCorr[1];
  assign uncorrB = rdUncorr[1];

  assert_zero_read_a_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == '0) |-> (rdDataA == '0 && !corrA && !uncorrA));
  assert_zero_read_b_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrB == '0) |-> (rdDataB == '0 && !corrB && !uncorrB));

  assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0) |=>
      ((rdAddrA != $past(wrAddr)) || (rdDataA == $past(wrData) && !corrA && !uncorrA)));
endmodule

// File: tb/ecc_regfile_tb.sv
module ecc_regfile_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  rdAddrA = '0;
  logic [4:0]  rdAddrB = '0;
  logic [31:0] rdDataA, rdDataB;
  logic        corrA, uncorrA, corrB, uncorrB;
  logic        injEn = 1'b0;
  logic [4:0]  injAddr = '0;
  logic [38:0] injMask = '0;

  always #10 clk = ~clk;

  ecc_regfile u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .corrA(corrA), .uncorrA(uncorrA), .corrB(corrB), .uncorrB(uncorrB),
    .injEn(injEn), .injAddr(injAddr), .injMask(injMask)
  );

  typedef struct {
    bit        port;
    bit [4:0]  addr;
    bit [31:0] data;
    bit        corr;
    bit        unc;
    bit        chkData;
    string     tag;
  } expItem_t;

  expItem_t  expQ[$];
  bit [31:0] mdl  [32];
  bit [38:0] errM [32];
  int        checks = 0;
  int        errors = 0;
  bit        done = 1'b0;

  function automatic void pushExp(bit port, bit [4:0] a, string tag);
    expItem_t it;
    int n;
    it.port = port; it.addr = a; it.tag = tag;
    n = $countones(errM[a]);
    it.chkData = (n < 2);
    it.data = (a == 0) ? 32'h0 : mdl[a];
    it.corr = (a != 0) && (n == 1);
    it.unc  = (a != 0) && (n >= 2);
    expQ.push_back(it);
  endfunction

  task automatic step(input bit wE, input bit [4:0] wA, input bit [31:0] wD,
                      input bit iE, input bit [4:0] iA, input bit [38:0] iM,
                      input bit [4:0] rA, input bit [4:0] rB, input string tag);
    @(negedge clk);
    wrEn = wE; wrAddr = wA; wrData = wD;
    injEn = iE; injAddr = iA; injMask = iM;
    rdAddrA = rA; rdAddrB = rB;
    pushExp(1'b0, rA, tag);
    pushExp(1'b1, rB, tag);
    if (wE && wA != 0) begin mdl[wA] = wD; errM[wA] = '0; end
    if (iE && iA != 0 && !(wE && wA == iA)) errM[iA] = errM[iA] ^ iM;
  endtask

  task automatic wr(input bit [4:0] a, input bit [31:0] d, input string tag);
    step(1, a, d, 0, 0, '0, 0, 0, tag);
  endtask
  task automatic rd(input bit [4:0] a, input bit [4:0] b, input string tag);
    step(0, 0, '0, 0, 0, '0, a, b, tag);
  endtask
  task automatic inj(input bit [4:0] a, input bit [38:0] m, input string tag);
    step(0, 0, '0, 1, a, m, 0, 0, tag);
  endtask

  // monitor: compare mid-way through the low phase, after inputs settled
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (expQ.size() > 0) begin
        expItem_t it;
        bit [31:0] aD;
        bit aC, aU;
        it = expQ.pop_front();
        aD = it.port ? rdDataB : rdDataA;
        aC = it.port ? corrB : corrA;
        aU = it.port ? uncorrB : uncorrA;
        checks++;
        if ((it.chkData && aD != it.data) || aC != it.corr || aU != it.unc) begin
          errors++;
          $display("FAIL %s port%0d addr%0d: actual data=%h corr=%b unc=%b expected data=%h corr=%b unc=%b",
                   it.tag, it.port, it.addr, aD, aC, aU, it.data, it.corr, it.unc);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin mdl[i] = '0; errM[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents
    for (int i = 0; i < 32; i++) rd(5'(i), 5'(31 - i), "R1 reset");

    // R2: fill and read back on both ports with distinct addresses
    for (int i = 1; i < 32; i++) wr(5'(i), (32'(i) * 32'h0101_0101) ^ 32'hA5C3_0F00, "R2 fill");
    for (int i = 1; i < 32; i++) rd(5'(i), 5'(32 - i), "R2 readback");
    wr(3, 32'hFFFF_FFFF, "R2 ones");
    wr(4, 32'h0000_0000, "R2 zeros");
    rd(3, 4, "R2 ones/zeros");

    // R3: same-cycle write and read returns the old value
    step(1, 5, 32'hDEAD_BEEF, 0, 0, '0, 5, 5, "R3 old value");
    rd(5, 6, "R3 new value");

    // R4: writes to entry 0 are dropped
    wr(0, 32'hFFFF_FFFF, "R4 write zero reg");
    rd(0, 0, "R4 zero reg");
    step(1, 0, 32'h1234_5678, 0, 0, '0, 0, 7, "R4 zero reg same cycle");

    // R5 / R9: each codeword bit, single flip is corrected
    for (int b = 0; b < 39; b++) begin
      inj(7, 39'(1) << b, "R5 R9 single inject");
      rd(7, 2, "R5 single corrected");
      wr(7, mdl[7], "R5 rewrite");
    end

    // R6: double flips flagged uncorrectable
    for (int b = 0; b < 39; b += 5) begin
      inj(8, (39'(1) << b) | (39'(1) << ((b + 17) % 39)), "R6 double inject");
      rd(8, 8, "R6 double detected");
      wr(8, mdl[8], "R6 rewrite");
      rd(8, 0, "R6 clean after rewrite");
    end

    // R7: injection into entry 0 has no effect; flags exclusive on both ports
    inj(0, 39'h3, "R7 inject zero reg");
    rd(0, 1, "R7 zero reg after inject");
    inj(11, 39'h10, "R7 single on 11");
    inj(12, 39'h100_0000, "R7 pre double on 12");
    inj(12, 39'h2, "R7 double on 12");
    rd(11, 12, "R7 both ports flagged");

    // R8: persistence, accumulation and write-beats-inject
    inj(10, 39'h800, "R8 inject 10");
    rd(10, 0, "R8 persists 1");
    rd(0, 10, "R8 persists 2");
    inj(10, 39'h800, "R8 same bit cancels");
    rd(10, 10, "R8 cancelled");
    step(1, 9, 32'hCAFE_F00D, 1, 9, 39'h5, 9, 0, "R8 write+inject same cycle");
    rd(9, 9, "R8 write wins");
    step(1, 13, 32'h0BAD_CAFE, 1, 14, 39'h4_0000_0000, 13, 14, "R8 write and inject different");
    rd(13, 14, "R8 independent targets");

    rd(0, 0, "R4 final");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule